// File: doc/BRIEF.md
# Integer Execute Unit with Built-in Instruction Decode

This combinational unit turns one 32-bit integer instruction word plus two source register values into the value to be written to the destination register. It handles the register-register class (opcode `0110011`) and the register-immediate class (opcode `0010011`). It reads the opcode, funct3 and funct7 fields straight from the instruction word. It also builds the sign-extended 12-bit immediate and the 5-bit shift amount itself, so the issue stage does not have to pre-decode an operation code.

The caller drives `instr_i`, `rs1_i` and `rs2_i` and reads `result_o` and `valid_o` in the same cycle. When `valid_o` is low, the word is not one this unit executes, and `result_o` is zero. Register file access, memory operations, control flow and pipelining are all outside this unit.

Field positions used throughout: opcode `instr[6:0]`, funct3 `instr[14:12]`, shift amount `instr[24:20]`, funct7 `instr[31:25]`, immediate `instr[31:20]` with `instr[31]` as its sign.

Top module: `rv_alu_exec`

## Requirements
- R1: funct3 `000` with funct7 `0000000` (register form), or funct3 `000` (immediate form), returns rs1 plus the second operand, modulo 2^32. The immediate is `instr[31:20]` sign-extended from `instr[31]`.
- R2: Register form, funct3 `000`, funct7 `0100000` returns rs1 minus rs2. The immediate form of funct3 `000` is always an add, whatever the upper immediate bits are.
- R3: funct3 `010` compares rs1 with the second operand as signed two's complement values. It returns 1 when rs1 is smaller, otherwise 0.
- R4: funct3 `011` compares as unsigned values and returns 1 or 0 in the same way. The immediate form compares against the sign-extended immediate, read as an unsigned 32-bit number.
- R5: funct3 `001` shifts rs1 left and fills with zeros. The shift amount is `rs2[4:0]` in register form and `instr[24:20]` in immediate form.
- R6: funct3 `101` shifts rs1 right. With `instr[30]` clear it fills with zeros. With `instr[30]` set (funct7 `0100000`) it fills with the original `rs1[31]`.
- R7: funct3 `100`, `110` and `111` return the bitwise XOR, OR and AND of rs1 and the second operand, for both register and immediate forms.
- R8: `valid_o` is high only for opcodes `0110011` and `0010011`. Register form accepts funct7 `0000000` for every funct3, and `0100000` only for funct3 `000` and `101`. Immediate shifts accept `instr[31:25]` equal to `0000000`, plus `0100000` for funct3 `101`. Any other word gives `valid_o` = 0 and `result_o` = 0.
- R9: Register shifts ignore `rs2[31:5]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| rs1_i | input | 32 | First source register value |
| rs2_i | input | 32 | Second source register value |
| result_o | output | 32 | Value for the destination register, zero when not valid |
| valid_o | output | 1 | High when the instruction is executed by this unit |

## Verification
The bench targets the sign boundary. It checks an add overflowing from `7fffffff`, and signed and unsigned compares of `ffffffff` against 1, where a design with the two compares swapped returns the opposite bit. For the unsigned compare-immediate it uses immediate `fff`: a zero-extending design would compare against `00000fff` and get the wrong answer. Shift checks use amounts of 0 and 31, an `rs2` with garbage above bit 4, and negative and positive operands for the arithmetic right shift, which expose a wrong fill bit or a shift amount taken from too many bits. Encoding checks include an immediate add whose upper bits look like the subtract funct7, and funct7 values that must be rejected, such as `0000001` and `0100000` on XOR or on a left shift.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;
  localparam int unsigned ILEN = 32;
  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR,  ALU_AND
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    use_imm;
    logic    valid;
  } dec_t;
endpackage

// File: rtl/rv_alu_decode.sv
module rv_alu_decode
  import rv_alu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [ILEN-1:0] instr_i,
  output dec_t            dec_o,
  output logic [XLEN-1:0] imm_o
);
  localparam int unsigned IMMW = 12;

  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic       f7_base, f7_alt;

  assign opc     = instr_i[6:0];
  assign f3      = instr_i[14:12];
  assign f7      = instr_i[31:25];
  assign f7_base = (f7 == F7_BASE);
  assign f7_alt  = (f7 == F7_ALT);

  // sign bit is always instr[31]
  assign imm_o = {{(XLEN-IMMW){instr_i[31]}}, instr_i[31:20]};

  alu_op_e base_op;
  always_comb begin
    case (f3)
      3'b000:  base_op = ALU_ADD;
      3'b001:  base_op = ALU_SLL;
      3'b010:  base_op = ALU_SLT;
      3'b011:  base_op = ALU_SLTU;
      3'b100:  base_op = ALU_XOR;
      3'b101:  base_op = ALU_SRL;
      3'b110:  base_op = ALU_OR;
      default: base_op = ALU_AND;
    endcase
  end

  always_comb begin
    dec_o.op      = base_op;
    dec_o.use_imm = 1'b0;
    dec_o.valid   = 1'b0;
    if (opc == OPC_REG) begin
      dec_o.valid = f7_base | (f7_alt & ((f3 == 3'b000) | (f3 == 3'b101)));
      if (f7_alt) dec_o.op = (f3 == 3'b000) ? ALU_SUB : ALU_SRA;
    end else if (opc == OPC_IMM) begin
      dec_o.use_imm = 1'b1;
      case (f3)
        3'b001: dec_o.valid = f7_base;
        3'b101: begin
          dec_o.valid = f7_base | f7_alt;
          if (f7_alt) dec_o.op = ALU_SRA;
        end
        default: dec_o.valid = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rv_alu_shift.sv
module rv_alu_shift #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] data_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] rev_in, rev_out;
  logic [XLEN-1:0] stg [SHW+1];
  logic            fill;

  // left shift = right shift of the bit-reversed word
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign rev_in[i]  = data_i[XLEN-1-i];
    assign rev_out[i] = stg[SHW][XLEN-1-i];
  end

  assign fill   = arith_i & ~left_i & data_i[XLEN-1];
  assign stg[0] = left_i ? rev_in : data_i;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{STEP{fill}}, stg[s][XLEN-1:STEP]} : stg[s];
  end

  assign res_o = left_i ? rev_out : stg[SHW];
endmodule

// File: rtl/rv_alu_core.sv
module rv_alu_core
  import rv_alu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN:0]   diff;
  logic [XLEN-1:0] sum, shift_res;
  logic            lt_u, lt_s;

  // one subtractor feeds both sub and the compares
  assign diff = {1'b0, a_i} - {1'b0, b_i};
  assign sum  = a_i + b_i;
  assign lt_u = diff[XLEN];
  assign lt_s = (a_i[XLEN-1] ^ b_i[XLEN-1]) ? a_i[XLEN-1] : lt_u;

  rv_alu_shift #(.XLEN(XLEN)) u_shift (
    .data_i (a_i),
    .amt_i  (b_i[SHW-1:0]),
    .left_i (op_i == ALU_SLL),
    .arith_i(op_i == ALU_SRA),
    .res_o  (shift_res)
  );

  always_comb begin
    case (op_i)
      ALU_ADD:                  res_o = sum;
      ALU_SUB:                  res_o = diff[XLEN-1:0];
      ALU_SLT:                  res_o = {{(XLEN-1){1'b0}}, lt_s};
      ALU_SLTU:                 res_o = {{(XLEN-1){1'b0}}, lt_u};
      ALU_XOR:                  res_o = a_i ^ b_i;
      ALU_OR:                   res_o = a_i | b_i;
      ALU_AND:                  res_o = a_i & b_i;
      ALU_SLL, ALU_SRL, ALU_SRA: res_o = shift_res;
      default:                  res_o = '0;
    endcase
  end
endmodule

// File: rtl/rv_alu_exec.sv
module rv_alu_exec
  import rv_alu_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic [31:0] rs1_i,
  input  logic [31:0] rs2_i,
  output logic [31:0] result_o,
  output logic        valid_o
);
  localparam int unsigned XLEN = 32;

  dec_t            dec;
  logic [XLEN-1:0] imm, op_b, core_res;

  rv_alu_decode #(.XLEN(XLEN)) u_dec (
    .instr_i(instr_i),
    .dec_o  (dec),
    .imm_o  (imm)
  );

  // shamt is the low bits of operand b in both forms
  assign op_b = dec.use_imm ? imm : rs2_i;

  rv_alu_core #(.XLEN(XLEN)) u_core (
    .op_i (dec.op),
    .a_i  (rs1_i),
    .b_i  (op_b),
    .res_o(core_res)
  );

  assign valid_o  = dec.valid;
  assign result_o = dec.valid ? core_res : '0;
endmodule

// File: rtl/rv_alu_exec_chk.sv
module rv_alu_exec_chk (
  input logic [31:0] instr_i,
  input logic [31:0] rs1_i,
  input logic [31:0] rs2_i,
  input logic [31:0] result_o,
  input logic        valid_o
);
  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [4:0] amt;
  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];
  assign f7  = instr_i[31:25];
  assign amt = (opc == 7'b0110011) ? rs2_i[4:0] : instr_i[24:20];

  always_comb begin
    if (opc != 7'b0110011 && opc != 7'b0010011)
      p_bad_opcode_r8: assert (!valid_o && result_o == 32'h0)
        else $error("R8 unsupported opcode accepted");
    if (valid_o && (f3 == 3'b010 || f3 == 3'b011))
      p_cmp_bool_r3: assert (result_o[31:1] == 31'h0)
        else $error("R3/R4 compare result not 0/1");
    if (opc == 7'b0110011 && f3 == 3'b000 && f7 == 7'b0100000 && rs1_i == rs2_i)
      p_sub_self_r2: assert (valid_o && result_o == 32'h0)
        else $error("R2 x-x nonzero");
    if (opc == 7'b0110011 && f3 == 3'b100 && f7 == 7'b0000000 && rs1_i == rs2_i)
      p_xor_self_r7: assert (valid_o && result_o == 32'h0)
        else $error("R7 x^x nonzero");
    if (valid_o && f3 == 3'b101 && !instr_i[30] && amt != 5'd0)
      p_srl_zero_fill_r6: assert (!result_o[31])
        else $error("R6 logical right shift filled ones");
    if (valid_o && f3 == 3'b101 && instr_i[30])
      p_sra_sign_r6: assert (result_o[31] == rs1_i[31])
        else $error("R6 arithmetic shift lost sign");
    if (valid_o && f3 == 3'b001 && amt != 5'd0)
      p_sll_zero_fill_r5: assert (!result_o[0])
        else $error("R5 left shift filled ones");
  end
endmodule

bind rv_alu_exec rv_alu_exec_chk u_chk (
  .instr_i (instr_i),
  .rs1_i   (rs1_i),
  .rs2_i   (rs2_i),
  .result_o(result_o),
  .valid_o (valid_o)
);

// File: tb/rv_alu_exec_test.sv
module rv_alu_exec_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] instr, a, b, res;
  logic        vld;

  rv_alu_exec uut (
    .instr_i (instr),
    .rs1_i   (a),
    .rs2_i   (b),
    .result_o(res),
    .valid_o (vld)
  );

  typedef struct {
    logic [31:0] res;
    logic        vld;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [31:0] rins(logic [6:0] f7, logic [2:0] f3);
    return {f7, 5'd2, 5'd1, f3, 5'd3, 7'b0110011};
  endfunction
  function automatic logic [31:0] iins(logic [11:0] imm, logic [2:0] f3);
    return {imm, 5'd1, f3, 5'd3, 7'b0010011};
  endfunction

  task automatic drive(input logic [31:0] ins, input logic [31:0] va, input logic [31:0] vb,
                       input logic [31:0] e_res, input logic e_vld, input string req);
    exp_t it;
    @(negedge clk);
    instr = ins; a = va; b = vb;
    it.res = e_res; it.vld = e_vld; it.req = req;
    q.push_back(it);
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(posedge clk);
      if (rst_ni && q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (res !== it.res || vld !== it.vld) begin
          fails++;
          $display("FAIL %s: got res=%08h valid=%b, expected res=%08h valid=%b",
                   it.req, res, vld, it.res, it.vld);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    instr = '0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle word: all-zero instruction is not executed
    drive(32'h0, 32'h0, 32'h0, 32'h0, 1'b0, "R8 reset/idle");
    // R1 add and sign-extended immediate
    drive(rins(7'h00, 3'b000), 32'h7fffffff, 32'h1, 32'h7fffffff + 32'h1, 1, "R1 add overflow");
    drive(rins(7'h00, 3'b000), 32'hffffffff, 32'h2, 32'h1, 1, "R1 add wrap");
    drive(iins(12'h800, 3'b000), 32'h0, 32'h12345678, 32'hfffff800, 1, "R1 addi negative imm");
    drive(iins(12'h7ff, 3'b000), 32'h1, 32'h0, 32'h00000800, 1, "R1 addi positive imm");
    // R2 subtract and immediate never subtracts
    drive(rins(7'h20, 3'b000), 32'd5, 32'd7, 32'hfffffffe, 1, "R2 sub");
    drive(iins(12'h405, 3'b000), 32'h0, 32'h0, 32'h00000405, 1, "R2 addi with alt-looking bits");
    // R3 signed compare
    drive(rins(7'h00, 3'b010), 32'hffffffff, 32'h1, 32'h1, 1, "R3 slt -1<1");
    drive(rins(7'h00, 3'b010), 32'h1, 32'hffffffff, 32'h0, 1, "R3 slt 1<-1");
    drive(iins(12'hffd, 3'b010), 32'hfffffffb, 32'h0, 32'h1, 1, "R3 slti -5<-3");
    // R4 unsigned compare
    drive(rins(7'h00, 3'b011), 32'hffffffff, 32'h1, 32'h0, 1, "R4 sltu");
    drive(iins(12'hfff, 3'b011), 32'h5, 32'h0, 32'h1, 1, "R4 sltiu imm sign-extended");
    drive(iins(12'hfff, 3'b011), 32'hffffffff, 32'h0, 32'h0, 1, "R4 sltiu equal");
    // R5 left shift
    drive(rins(7'h00, 3'b001), 32'h1, 32'd31, 32'h80000000, 1, "R5 sll 31");
    drive(iins(12'h008, 3'b001), 32'h0000ffff, 32'h0, 32'h00ffff00, 1, "R5 slli 8");
    // R9 high rs2 bits ignored
    drive(rins(7'h00, 3'b001), 32'h1, 32'h23, 32'h8, 1, "R9 sll uses rs2[4:0]");
    drive(rins(7'h00, 3'b101), 32'h80000000, 32'hffffffe4, 32'h08000000, 1, "R9 srl uses rs2[4:0]");
    // R6 right shifts
    drive(rins(7'h00, 3'b101), 32'h80000000, 32'd31, 32'h1, 1, "R6 srl 31");
    drive(rins(7'h20, 3'b101), 32'h80000000, 32'd31, 32'hffffffff, 1, "R6 sra 31");
    drive(rins(7'h20, 3'b101), 32'h80000000, 32'd0, 32'h80000000, 1, "R6 sra 0");
    drive(rins(7'h20, 3'b101), 32'h40000000, 32'd1, 32'h20000000, 1, "R6 sra positive");
    drive(iins({7'h20, 5'd4}, 3'b101), 32'hf0000000, 32'h0, 32'hff000000, 1, "R6 srai");
    drive(iins({7'h00, 5'd4}, 3'b101), 32'hf0000000, 32'h0, 32'h0f000000, 1, "R6 srli");
    // R7 bitwise
    drive(rins(7'h00, 3'b100), 32'hf0f0a5a5, 32'h0ff05a5a, 32'hff00ffff, 1, "R7 xor");
    drive(rins(7'h00, 3'b110), 32'hf0f0a5a5, 32'h0ff05a5a, 32'hfff0ffff, 1, "R7 or");
    drive(rins(7'h00, 3'b111), 32'hf0f0a5a5, 32'h0ff05a5a, 32'h00f00000, 1, "R7 and");
    drive(iins(12'hfff, 3'b100), 32'hf0f0a5a5, 32'h0, 32'h0f0f5a5a, 1, "R7 xori");
    drive(iins(12'h00f, 3'b110), 32'hf0f0a5a5, 32'h0, 32'hf0f0a5af, 1, "R7 ori");
    drive(iins(12'h0f0, 3'b111), 32'hf0f0a5a5, 32'h0, 32'h000000a0, 1, "R7 andi");
    // R8 rejected encodings
    drive(rins(7'h01, 3'b000), 32'h3, 32'h4, 32'h0, 0, "R8 funct7 0000001");
    drive(rins(7'h20, 3'b100), 32'h3, 32'h4, 32'h0, 0, "R8 alt funct7 on xor");
    drive(iins({7'h20, 5'd1}, 3'b001), 32'h3, 32'h0, 32'h0, 0, "R8 alt funct7 on slli");
    drive(iins({7'h01, 5'd1}, 3'b101), 32'h3, 32'h0, 32'h0, 0, "R8 bad funct7 on srli");
    drive({12'h001, 5'd1, 3'b000, 5'd3, 7'b0000011}, 32'h3, 32'h4, 32'h0, 0, "R8 other opcode");
    @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule